// File: doc/BRIEF.md
# PLL Setting Search Engine

This block finds divider and multiplier settings for a clock synthesiser. After a start pulse it captures three 32-bit values: the reference frequency, the wanted output frequency and the largest error that is allowed, all in hertz. It then tries every pairing of post-divide value and input divide value. For each pairing it works out the multiplier that pairing needs, along with the internal frequencies that follow from it. It keeps the legal pairing with the smallest error. On completion it reports whether any pairing qualified, a packed 32-bit mode word and the output frequency that setting really gives.

All quotients come from one shared shift-subtract divider inside the block, and the few products come from plain multipliers. The block only computes a setting. It has no link to an oscillator or to a clock switch. The handshake is a single-cycle start input, a busy level and a one-cycle done strobe. Results remain valid until the next accepted start.

Top module: `pll_cfg_search`

## Requirements
- R1: A run ends with found low, mode 0 and frequency 0, and does no search, when the reference lies outside 250,000..500,000,000 or the target lies outside 3,333,333..500,000,000 (both bounds inclusive are legal).
- R2: The outer loop steps an index k from 0 to 15, with post value 1 for k=0 and 2k otherwise. For each k the input divider D counts down from 64 to 1. The best-error register starts at the allowed error. A candidate whose error is less than or equal to the best so far replaces it, so a later candidate wins a tie.
- R3: Every quotient is rounded to nearest as ((2·n)/d + 1)/2 using integer division. The four quotients are: phase-detector frequency = ref/D; multiplier M = post·D·target/ref; VCO = ref·M/D; output = VCO/post. Each is computed in that order.
- R4: A candidate is legal only if the phase-detector frequency is at least 250,000, M is at most 1024 and the VCO is at least 99,000,000.
- R5: A VCO above 201,000,000 is legal only if it does not exceed target plus allowed error, with that sum taken without wrap.
- R6: The mode word of an accepted candidate is laid out as follows. Bits 23:18 hold D−1. Bits 17:8 hold M−1. Bits 7:4 hold (k−1) mod 16, so k=0 gives 4'b1111. Bit 24 is 1. Bits 1:0 are 2'b11. Bits 3:2 and bits 31:25 are 0.
- R7: found goes high if and only if some candidate was accepted. The frequency output then equals the rounded output frequency of the last accepted candidate. If no candidate is accepted, mode and frequency are 0.
- R8: A start that arrives while busy is high, including in the cycle done is high, has no effect on the run or on its result.
- R9: found, mode and frequency do not change from the done strobe until the next accepted start.
- R10: When the doubled reference times M, divided by 2^32, is not below D, the VCO is forced to 0 for that candidate, which makes it fail R4.
- R11: busy rises in the cycle after an accepted start. done is high for exactly one cycle while busy is high. Both are low in the following cycle and out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| ref_hz_i | input | 32 | Reference frequency in Hz |
| target_hz_i | input | 32 | Wanted output frequency in Hz |
| tol_hz_i | input | 32 | Largest allowed error in Hz |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion strobe |
| found_o | output | 1 | A legal setting was found |
| mode_o | output | 32 | Packed mode word |
| freq_o | output | 32 | Output frequency the setting achieves |

## Verification
Two events can meet in one cycle: the completion strobe of a run and a new start request. The bench raises start in exactly the cycle where done is seen high, with different operands. It also raises start once in the middle of a run. The scoreboard must then receive exactly one result per accepted run, and that result must match the bench's own exhaustive model of the search. Busy must drop after the strobe with no second strobe, and the held outputs must stay at the first run's values.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int unsigned FREQ_W = 32;
  localparam int unsigned PROD_W = 64;

  localparam logic [FREQ_W-1:0] REF_LO    = 32'd250_000;
  localparam logic [FREQ_W-1:0] REF_HI    = 32'd500_000_000;
  localparam logic [FREQ_W-1:0] TGT_LO    = 32'd3_333_333;
  localparam logic [FREQ_W-1:0] TGT_HI    = 32'd500_000_000;
  localparam logic [FREQ_W-1:0] PFD_FLOOR = 32'd250_000;
  localparam logic [FREQ_W-1:0] MUL_CEIL  = 32'd1024;
  localparam logic [FREQ_W-1:0] VCO_FLOOR = 32'd99_000_000;
  localparam logic [FREQ_W-1:0] VCO_SOFT  = 32'd201_000_000;

  // mode word field widths (fixed by the encoding)
  localparam int unsigned DF_W = 6;
  localparam int unsigned MF_W = 10;
  localparam int unsigned PF_W = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_ISSUE, S_WAIT, S_EVAL, S_FIN
  } srch_state_e;

  typedef enum logic [1:0] {
    OP_PFD = 2'd0, OP_MUL = 2'd1, OP_VCO = 2'd2, OP_OUT = 2'd3
  } srch_op_e;

endpackage

// File: rtl/pll_div_unit.sv
module pll_div_unit #(
  parameter int unsigned NUM_W  = 64,
  parameter int unsigned DEN_W  = 32,
  parameter int unsigned Q_BITS = 40,
  parameter int unsigned Q_STEP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [DEN_W-1:0]  den_i,
  output logic              done_o,
  output logic [Q_BITS-1:0] quot_o
);
  localparam int unsigned ITER = Q_BITS / Q_STEP;
  localparam int unsigned CW   = $clog2(ITER + 1);
  localparam int unsigned HI_W = NUM_W - Q_BITS;
  localparam int unsigned PW   = Q_BITS + DEN_W + 8;

  logic [DEN_W-1:0]  rem_q, rem_d;
  logic [Q_BITS-1:0] acc_q, acc_d;
  logic [DEN_W-1:0]  den_q, den_d;
  logic [NUM_W-1:0]  num_q, num_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              run_q, run_d;
  logic              done_q, done_d;
  logic              en;

  logic [DEN_W:0]    trial;
  logic [DEN_W-1:0]  r_w;
  logic [Q_BITS-1:0] a_w;

  // Q_STEP restoring steps per clock
  always_comb begin
    r_w   = rem_q;
    a_w   = acc_q;
    trial = '0;
    for (int k = 0; k < Q_STEP; k++) begin
      trial = {r_w, a_w[Q_BITS-1]};
      a_w   = {a_w[Q_BITS-2:0], 1'b0};
      if (trial >= {1'b0, den_q}) begin
        trial  = trial - {1'b0, den_q};
        a_w[0] = 1'b1;
      end
      r_w = trial[DEN_W-1:0];
    end
  end

  always_comb begin
    rem_d  = rem_q;
    acc_d  = acc_q;
    den_d  = den_q;
    num_d  = num_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go_i) begin
      rem_d = {{(DEN_W-HI_W){1'b0}}, num_i[NUM_W-1:Q_BITS]};
      acc_d = num_i[Q_BITS-1:0];
      den_d = den_i;
      num_d = num_i;
      cnt_d = CW'(ITER);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = r_w;
      acc_d = a_w;
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  assign en = go_i | run_q | done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      acc_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (en) begin
      rem_q  <= rem_d;
      acc_q  <= acc_d;
      den_q  <= den_d;
      num_q  <= num_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign quot_o = acc_q;

  // R3: quotient and remainder reconstruct the latched dividend
  p_quot_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((PW'(acc_q) * PW'(den_q) + PW'(rem_q)) == PW'(num_q)) && (rem_q < den_q));

endmodule

// File: rtl/pll_mode_pack.sv
module pll_mode_pack import pll_search_pkg::*; #(
  parameter int unsigned DIV_W = 7,
  parameter int unsigned IDX_W = 4
) (
  input  logic [DIV_W-1:0]  dv_i,
  input  logic [MF_W-1:0]   mul_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [FREQ_W-1:0] mode_o
);
  logic [DIV_W-1:0] dv_m1;
  logic [MF_W-1:0]  mul_m1;
  logic [IDX_W-1:0] idx_m1;

  assign dv_m1  = dv_i - 1'b1;
  assign mul_m1 = mul_i - 1'b1;
  assign idx_m1 = idx_i - 1'b1;

  assign mode_o = {7'b0, 1'b1, DF_W'(dv_m1), mul_m1, PF_W'(idx_m1), 2'b00, 2'b11};

endmodule

// File: rtl/pll_cfg_search.sv
module pll_cfg_search import pll_search_pkg::*; #(
  parameter int unsigned DIV_MAX    = 64,
  parameter int unsigned POST_STEPS = 16,
  parameter int unsigned Q_BITS     = 40,
  parameter int unsigned Q_STEP     = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] ref_hz_i,
  input  logic [31:0] target_hz_i,
  input  logic [31:0] tol_hz_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        found_o,
  output logic [31:0] mode_o,
  output logic [31:0] freq_o
);
  localparam int unsigned IDX_W  = $clog2(POST_STEPS);
  localparam int unsigned DIV_W  = $clog2(DIV_MAX + 1);
  localparam int unsigned POST_W = IDX_W + 1;
  localparam int unsigned SC_W   = POST_W + DIV_W + 1;

  srch_state_e       state_q, state_d;
  srch_op_e          op_q, op_d;
  logic [FREQ_W-1:0] ref_q, ref_d, tgt_q, tgt_d, tol_q, tol_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DIV_W-1:0]  dv_q, dv_d;
  logic [FREQ_W-1:0] pfd_q, pfd_d, mul_q, mul_d, vco_q, vco_d, fout_q, fout_d;
  logic [FREQ_W-1:0] best_q, best_d, mode_q, mode_d, freq_q, freq_d;
  logic              found_q, found_d;

  logic              div_go, div_done;
  logic [PROD_W-1:0] div_num;
  logic [FREQ_W-1:0] div_den;
  logic [Q_BITS-1:0] div_quot;
  logic [Q_BITS:0]   q_inc;
  logic [FREQ_W-1:0] rnd;

  logic [POST_W-1:0] post;
  logic [SC_W-1:0]   scale;
  logic [PROD_W-1:0] mul_num, vco_num;
  logic              vco_ovf, in_range;
  logic [FREQ_W-1:0] abs_err;
  logic [FREQ_W:0]   vco_cap;
  logic              accept;
  logic [FREQ_W-1:0] packed_mode;

  assign post    = (idx_q == '0) ? POST_W'(1) : {idx_q, 1'b0};
  assign scale   = (SC_W'(post) * SC_W'(dv_q)) << 1;
  assign mul_num = PROD_W'(scale) * PROD_W'(tgt_q);
  assign vco_num = PROD_W'({ref_q, 1'b0}) * PROD_W'(mul_q);
  assign vco_ovf = vco_num[PROD_W-1:FREQ_W] >= FREQ_W'(dv_q);

  assign in_range = (ref_q >= REF_LO) && (ref_q <= REF_HI) &&
                    (tgt_q >= TGT_LO) && (tgt_q <= TGT_HI);

  assign q_inc = {1'b0, div_quot} + 1'b1;
  assign rnd   = (|q_inc[Q_BITS:FREQ_W+1]) ? '1 : q_inc[FREQ_W:1];

  assign abs_err = (fout_q >= tgt_q) ? (fout_q - tgt_q) : (tgt_q - fout_q);
  assign vco_cap = {1'b0, tgt_q} + {1'b0, tol_q};
  assign accept  = (abs_err <= best_q) && (pfd_q >= PFD_FLOOR) &&
                   (mul_q <= MUL_CEIL) && (vco_q >= VCO_FLOOR) &&
                   ((vco_q <= VCO_SOFT) || ({1'b0, vco_q} <= vco_cap));

  always_comb begin
    div_num = '0;
    div_den = '0;
    unique case (op_q)
      OP_PFD: begin div_num = PROD_W'({ref_q, 1'b0}); div_den = FREQ_W'(dv_q); end
      OP_MUL: begin div_num = mul_num;                div_den = ref_q;         end
      OP_VCO: begin div_num = vco_num;                div_den = FREQ_W'(dv_q); end
      OP_OUT: begin div_num = PROD_W'({vco_q, 1'b0}); div_den = FREQ_W'(post); end
      default: ;
    endcase
  end

  pll_div_unit #(
    .NUM_W(PROD_W), .DEN_W(FREQ_W), .Q_BITS(Q_BITS), .Q_STEP(Q_STEP)
  ) div_i (
    .clk(clk), .rst_n(rst_n), .go_i(div_go), .num_i(div_num),
    .den_i(div_den), .done_o(div_done), .quot_o(div_quot)
  );

  pll_mode_pack #(.DIV_W(DIV_W), .IDX_W(IDX_W)) pack_i (
    .dv_i(dv_q), .mul_i(mul_q[MF_W-1:0]), .idx_i(idx_q), .mode_o(packed_mode)
  );

  always_comb begin
    state_d = state_q;  op_d   = op_q;
    ref_d   = ref_q;    tgt_d  = tgt_q;  tol_d = tol_q;
    idx_d   = idx_q;    dv_d   = dv_q;
    pfd_d   = pfd_q;    mul_d  = mul_q;  vco_d = vco_q;  fout_d = fout_q;
    best_d  = best_q;   found_d = found_q;
    mode_d  = mode_q;   freq_d = freq_q;
    div_go  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        ref_d   = ref_hz_i;
        tgt_d   = target_hz_i;
        tol_d   = tol_hz_i;
        best_d  = tol_hz_i;
        found_d = 1'b0;
        mode_d  = '0;
        freq_d  = '0;
        idx_d   = '0;
        dv_d    = DIV_W'(DIV_MAX);
        state_d = S_CHK;
      end
      S_CHK: begin
        op_d    = OP_PFD;
        state_d = in_range ? S_ISSUE : S_FIN;
      end
      S_ISSUE: begin
        if (op_q == OP_VCO && vco_ovf) begin
          vco_d = '0;
          op_d  = OP_OUT;
        end else begin
          div_go  = 1'b1;
          state_d = S_WAIT;
        end
      end
      S_WAIT: if (div_done) begin
        unique case (op_q)
          OP_PFD: pfd_d  = rnd;
          OP_MUL: mul_d  = rnd;
          OP_VCO: vco_d  = rnd;
          OP_OUT: fout_d = rnd;
          default: ;
        endcase
        if (op_q == OP_OUT) state_d = S_EVAL;
        else begin
          op_d    = srch_op_e'(op_q + 2'd1);
          state_d = S_ISSUE;
        end
      end
      S_EVAL: begin
        if (accept) begin
          best_d  = abs_err;
          found_d = 1'b1;
          mode_d  = packed_mode;
          freq_d  = fout_q;
        end
        op_d = OP_PFD;
        if (dv_q == DIV_W'(1)) begin
          if (idx_q == IDX_W'(POST_STEPS - 1)) state_d = S_FIN;
          else begin
            idx_d   = idx_q + 1'b1;
            dv_d    = DIV_W'(DIV_MAX);
            state_d = S_ISSUE;
          end
        end else begin
          dv_d    = dv_q - 1'b1;
          state_d = S_ISSUE;
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  op_q   <= OP_PFD;
      ref_q   <= '0;      tgt_q  <= '0;  tol_q <= '0;
      idx_q   <= '0;      dv_q   <= '0;
      pfd_q   <= '0;      mul_q  <= '0;  vco_q <= '0;  fout_q <= '0;
      best_q  <= '0;      found_q <= 1'b0;
      mode_q  <= '0;      freq_q <= '0;
    end else begin
      state_q <= state_d; op_q   <= op_d;
      ref_q   <= ref_d;   tgt_q  <= tgt_d; tol_q <= tol_d;
      idx_q   <= idx_d;   dv_q   <= dv_d;
      pfd_q   <= pfd_d;   mul_q  <= mul_d; vco_q <= vco_d; fout_q <= fout_d;
      best_q  <= best_d;  found_q <= found_d;
      mode_q  <= mode_d;  freq_q <= freq_d;
    end
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_FIN);
  assign found_o = found_q;
  assign mode_o  = mode_q;
  assign freq_o  = freq_q;

  p_abort_nofound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ((ref_q < REF_LO) || (ref_q > REF_HI) || (tgt_q < TGT_LO) || (tgt_q > TGT_HI)))
    |-> !found_o);

  p_err_within_tol_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o) |-> (((freq_o >= tgt_q) ? (freq_o - tgt_q) : (tgt_q - freq_o)) <= tol_q));

  p_mode_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o) |-> (mode_o[1:0] == 2'b11 && mode_o[24] && mode_o[3:2] == 2'b00 &&
                             mode_o[31:25] == 7'd0));

  p_empty_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !found_o) |-> (mode_o == '0 && freq_o == '0));

  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(ref_q) && $stable(tgt_q) && $stable(tol_q)));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(found_o) && $stable(mode_o) && $stable(freq_o)));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

endmodule

// File: tb/pll_cfg_search_tb_top.sv
module pll_cfg_search_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk, rst_n, start_i;
  logic [31:0] ref_hz_i, target_hz_i, tol_hz_i;
  logic        busy_o, done_o, found_o;
  logic [31:0] mode_o, freq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    bit          found;
    logic [31:0] mode;
    logic [31:0] freq;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  pll_cfg_search dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_hz_i(ref_hz_i),
    .target_hz_i(target_hz_i), .tol_hz_i(tol_hz_i), .busy_o(busy_o),
    .done_o(done_o), .found_o(found_o), .mode_o(mode_o), .freq_o(freq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // independent exhaustive model of the search
  function automatic exp_t model(input longint unsigned xin, input longint unsigned tgt,
                                 input longint unsigned tol, input string tag);
    exp_t e;
    longint unsigned best, post, pfd, mu, prod, vco, fo, ab, m;
    e.found = 0; e.mode = '0; e.freq = '0; e.tag = tag;
    if (xin < 250000 || xin > 500000000 || tgt < 3333333 || tgt > 500000000) return e;
    best = tol;
    for (int k = 0; k < 16; k++) begin
      post = (k == 0) ? 1 : 2 * k;
      for (int d = 64; d >= 1; d--) begin
        pfd  = ((2 * xin) / d + 1) / 2;
        mu   = ((2 * post * d * tgt) / xin + 1) / 2;
        prod = 2 * xin * mu;
        if ((prod >> 32) >= d) vco = 0;
        else vco = ((prod / d) + 1) / 2;
        fo = ((2 * vco) / post + 1) / 2;
        ab = (fo >= tgt) ? fo - tgt : tgt - fo;
        if (ab <= best && pfd >= 250000 && mu <= 1024 && vco >= 99000000 &&
            (vco <= 201000000 || vco <= tgt + tol)) begin
          best = ab;
          m = ((longint'(d) - 1) << 18) | (((mu - 1) & 1023) << 8) |
              (longint'((k - 1) & 15) << 4) | 64'h01000003;
          e.found = 1;
          e.mode  = m[31:0];
          e.freq  = fo[31:0];
        end
      end
    end
    return e;
  endfunction

  // monitor: pops expected results as the design completes
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, "found", found_o, e.found);
        chk(e.tag, "mode",  mode_o,  e.mode);
        chk(e.tag, "freq",  freq_o,  e.freq);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_case(input logic [31:0] xin, input logic [31:0] tgt,
                          input logic [31:0] tol, input string tag,
                          input bit poke_mid, input bit poke_done);
    exp_t e;
    e = model(xin, tgt, tol, tag);
    sb_q.push_back(e);
    @(negedge clk);
    ref_hz_i = xin; target_hz_i = tgt; tol_hz_i = tol; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R11", "busy after start", busy_o, 1);
    if (poke_mid) begin
      repeat (40) @(negedge clk);
      ref_hz_i = 32'd12_000_000; target_hz_i = 32'd77_000_000; tol_hz_i = 32'd0;
      start_i = 1'b1;  // R8: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    if (poke_done) begin
      ref_hz_i = 32'd10_000_000; target_hz_i = 32'd90_000_000; tol_hz_i = 32'd5;
      start_i = 1'b1;  // R8: coincides with done
    end
    @(negedge clk);
    start_i = 1'b0;
    chk("R11", "done one cycle", done_o, 0);
    chk("R11 R8", "busy after done", busy_o, 0);
    repeat (10) @(negedge clk);
    chk("R9", "held found", found_o, e.found);
    chk("R9", "held mode",  mode_o,  e.mode);
    chk("R9", "held freq",  freq_o,  e.freq);
    chk("R8", "busy stays low", busy_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    ref_hz_i = '0; target_hz_i = '0; tol_hz_i = '0;
    repeat (3) @(negedge clk);
    chk("R11", "reset busy",  busy_o,  0);
    chk("R11", "reset done",  done_o,  0);
    chk("R7",  "reset found", found_o, 0);
    chk("R7",  "reset mode",  mode_o,  0);
    chk("R7",  "reset freq",  freq_o,  0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: range aborts
    run_case(32'd100_000,     32'd100_000_000, 32'd1000, "R1 ref low",   0, 0);
    run_case(32'd500_000_001, 32'd100_000_000, 32'd0,    "R1 ref high",  0, 0);
    run_case(32'd20_000_000,  32'd3_333_332,   32'd1000, "R1 tgt low",   0, 0);
    run_case(32'd20_000_000,  32'd500_000_001, 32'd1000, "R1 tgt high",  0, 0);
    // exact ratio, ties resolved by later candidate, k=0 field
    run_case(32'd20_000_000,  32'd180_000_000, 32'd0,      "R2 R3 R6",    0, 0);
    // low target needs post divide; mid-run start ignored
    run_case(32'd20_000_000,  32'd50_000_000,  32'd100_000, "R2 R4 R6 R8", 1, 0);
    // VCO above soft ceiling allowed by tolerance
    run_case(32'd20_000_000,  32'd300_000_000, 32'd1_000_000, "R5",       0, 0);
    // large ratios overflow the VCO quotient
    run_case(32'd500_000_000, 32'd500_000_000, 32'd1_000_000, "R10 R4",   0, 0);
    // zero tolerance odd values; start coinciding with done
    run_case(32'd19_999_999,  32'd123_456_791, 32'd0,  "R7 R3 R8",        0, 1);

    repeat (5) @(negedge clk);
    chk("R8", "pending results", sb_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule